// File: doc/BRIEF.md
# Configurable Pin Interrupt Detector

This block watches an 8-bit general-purpose input port and turns pin activity into per-pin pending flags and a single interrupt request. Every pin is first brought into the clock domain by a flop chain. Each pin then has its own trigger mode. It can sense a level, either active-high or active-low. It can also sense an edge: rising only, falling only, or both directions.

A trigger event sets the pin's pending flag in hardware. Only an acknowledge write, which clears by writing ones, can take the flag down. An enable register selects which pending flags reach the masked view and the combined `irq` output. Software can also leave every enable bit clear and poll the pending register instead.

All settings and views are reached through a flat register port. A write takes effect on the clock edge that samples it. A read is combinational from the address.

Top module: `pin_irq_detector`

## Requirements
- R1: After reset, all mode, dual, polarity and enable bits are zero (every pin on falling edge), no pending flag is set and `irq` is low.
- R2: The mode register (address 0) chooses the trigger type per bit: 0 selects edge sensing, 1 selects level sensing.
- R3: The polarity register (address 2) sets the direction per bit. In edge mode, 1 means rising and 0 means falling. In level mode, 1 means active-high and 0 means active-low.
- R4: A dual bit set to 1 (address 1) makes an edge-mode pin trigger on both transitions, whatever its polarity bit says.
- R5: A pin change applied between clock edges sets the pending flag on the third rising clock edge that follows, and not before.
- R6: A level-mode pin holds its pending flag set for as long as the pin stays at the active level, even through acknowledge writes. Once the pin is inactive, an acknowledge clears the flag.
- R7: The pending register (address 4) is read-only. Writing it leaves its contents unchanged.
- R8: Writing to the acknowledge address (6) clears only the pending bits written as 1, and that address reads as zero. If a trigger event and an acknowledge reach the same bit in the same cycle, the bit stays set.
- R9: The masked view (address 5) equals pending AND enable (address 3). `irq` is high exactly when any masked bit is set.
- R10: A trigger event that falls in the same cycle as a write to the mode, dual or polarity register is discarded. Changing the configuration never creates an event by itself.
- R11: Address 7 reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pin_in | input | 8 | Asynchronous port pins |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data, one bit per pin |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench uses the defaults: 8 pins, a two-stage synchroniser, and the dual-edge option present. With these values the three-edge latency of R5 can be timed exactly. The bench can also place an acknowledge or a configuration write in the one cycle where a trigger event is live, which covers R8 and R10. A table of per-pin mixes sets every pin to a different mode and polarity at once, so one readback covers all eight detectors.

// File: rtl/pid_pkg.sv
package pid_pkg;
   localparam int ADDR_W = 3;

   typedef enum logic [ADDR_W-1:0] {
      SEL_MODE   = 3'd0,
      SEL_DUAL   = 3'd1,
      SEL_POLAR  = 3'd2,
      SEL_ENABLE = 3'd3,
      SEL_PEND   = 3'd4,
      SEL_ACTIVE = 3'd5,
      SEL_ACK    = 3'd6
   } reg_sel_e;
endpackage

// File: rtl/pid_sync.sv
module pid_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pid_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pid_cfg.sv
module pid_cfg
   import pid_pkg::*;
#(
   parameter int W        = 8,
   parameter bit HAS_DUAL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [W-1:0]      wdata,
   output logic [W-1:0]      mode,
   output logic [W-1:0]      dual,
   output logic [W-1:0]      polar,
   output logic [W-1:0]      enable,
   output logic [W-1:0]      ack,
   output logic              cfg_wr
);
   logic hit_mode, hit_dual, hit_polar, hit_enable, hit_ack;

   assign hit_mode   = wr && (addr == SEL_MODE);
   assign hit_dual   = wr && (addr == SEL_DUAL);
   assign hit_polar  = wr && (addr == SEL_POLAR);
   assign hit_enable = wr && (addr == SEL_ENABLE);
   assign hit_ack    = wr && (addr == SEL_ACK);

   assign cfg_wr = hit_mode | hit_dual | hit_polar;
   assign ack    = hit_ack ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode   <= '0;
         polar  <= '0;
         enable <= '0;
      end else begin
         if (hit_mode)   mode   <= wdata;
         if (hit_polar)  polar  <= wdata;
         if (hit_enable) enable <= wdata;
      end
   end

   if (HAS_DUAL) begin : g_dual
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        dual <= '0;
         else if (hit_dual) dual <= wdata;
      end
   end else begin : g_no_dual
      assign dual = '0;
   end
endmodule

// File: rtl/pid_trigger.sv
module pid_trigger #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] smp,
   input  logic [W-1:0] mode,
   input  logic [W-1:0] dual,
   input  logic [W-1:0] polar,
   input  logic         cfg_wr,
   output logic [W-1:0] evt
);
   logic [W-1:0] prev;
   logic [W-1:0] rise, fall, lvl_hit, edge_hit;

   // prev always holds the last synchronised sample, so a configuration
   // change never compares against a stale value.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '0;
      else        prev <= smp;
   end

   assign rise     = smp & ~prev;
   assign fall     = ~smp & prev;
   assign lvl_hit  = mode & ~(smp ^ polar);
   assign edge_hit = ~mode & ((polar & rise) | (~polar & fall) | (dual & (rise | fall)));
   assign evt      = (lvl_hit | edge_hit) & ~{W{cfg_wr}};

   // R2
   edge_needs_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt & ~mode & ~(smp ^ $past(smp))) == '0));

   // R10
   cfg_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr |-> (evt == '0));
endmodule

// File: rtl/pid_status.sv
module pid_status #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic [W-1:0] ack,
   output logic [W-1:0] pend
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend <= '0;
      else        pend <= (pend & ~ack) | evt;
   end

   // R7
   set_only_by_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((pend & ~$past(pend) & ~$past(evt)) == '0));

   // R8
   event_beats_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(evt)) & ~pend) == '0));

   // R8
   ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(ack) & ~$past(evt)) & pend) == '0));
endmodule

// File: rtl/pin_irq_detector.sv
module pin_irq_detector
   import pid_pkg::*;
#(
   parameter int NUM_PINS    = 8,
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_DUAL    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_in,
   input  logic                reg_wr,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [NUM_PINS-1:0] reg_wdata,
   output logic [NUM_PINS-1:0] reg_rdata,
   output logic                irq
);
   if (NUM_PINS < 1 || NUM_PINS > 64) begin : g_bad_pins
      $error("pin_irq_detector: NUM_PINS out of range");
   end

   logic [NUM_PINS-1:0] smp, mode, dual, polar, enable, ack, evt, pend, active;
   logic                cfg_wr;

   pid_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(smp));

   pid_cfg #(.W(NUM_PINS), .HAS_DUAL(HAS_DUAL)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .mode(mode), .dual(dual), .polar(polar), .enable(enable),
      .ack(ack), .cfg_wr(cfg_wr));

   pid_trigger #(.W(NUM_PINS)) u_trig (
      .clk(clk), .rst_n(rst_n), .smp(smp), .mode(mode), .dual(dual),
      .polar(polar), .cfg_wr(cfg_wr), .evt(evt));

   pid_status #(.W(NUM_PINS)) u_stat (
      .clk(clk), .rst_n(rst_n), .evt(evt), .ack(ack), .pend(pend));

   assign active = pend & enable;
   assign irq    = |active;

   always_comb begin
      case (reg_addr)
         SEL_MODE:   reg_rdata = mode;
         SEL_DUAL:   reg_rdata = dual;
         SEL_POLAR:  reg_rdata = polar;
         SEL_ENABLE: reg_rdata = enable;
         SEL_PEND:   reg_rdata = pend;
         SEL_ACTIVE: reg_rdata = active;
         default:    reg_rdata = '0;
      endcase
   end

   // R9
   irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (pend != '0));

   // R9
   irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (enable == '0) |-> !irq);
endmodule

// File: tb/tb_pin_irq_detector.sv
module tb_pin_irq_detector;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] pin_in = '0;
   logic       reg_wr = 1'b0;
   logic [2:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   pin_irq_detector dut (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

   localparam logic [2:0] A_MODE = 3'd0, A_DUAL = 3'd1, A_POL = 3'd2, A_EN = 3'd3,
                          A_PEND = 3'd4, A_ACT = 3'd5, A_ACK = 3'd6, A_NONE = 3'd7;

   // mode, dual, polarity, pins before, pins after, expected pending
   localparam int NV = 6;
   localparam logic [47:0] VEC [NV] = '{
      {8'h00, 8'h00, 8'h00, 8'hFF, 8'h0F, 8'hF0},
      {8'h00, 8'h00, 8'hFF, 8'h00, 8'h3C, 8'h3C},
      {8'h00, 8'hFF, 8'h00, 8'h0F, 8'hF0, 8'hFF},
      {8'hFF, 8'h00, 8'hAA, 8'hA0, 8'hA0, 8'hF5},
      {8'h0F, 8'h00, 8'h03, 8'hF5, 8'h55, 8'hA9},
      {8'h00, 8'h00, 8'hFF, 8'hFF, 8'hFF, 8'h00}
   };

   task automatic check(string req, logic [7:0] got, logic [7:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr_reg(logic [2:0] a, logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_cyc(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; pin_in = '0; reg_wr = 1'b0;
      wait_cyc(3);
      rst_n = 1'b1;
      wait_cyc(2);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: got hung expected finish");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      do_reset();

      // R1 reset state
      rd_reg(A_MODE, v); check("R1 mode", v, 8'h00);
      rd_reg(A_DUAL, v); check("R1 dual", v, 8'h00);
      rd_reg(A_POL,  v); check("R1 polarity", v, 8'h00);
      rd_reg(A_EN,   v); check("R1 enable", v, 8'h00);
      rd_reg(A_PEND, v); check("R1 pending", v, 8'h00);
      check("R1 irq", {7'd0, irq}, 8'h00);

      // R2 R3 R4 vector table
      for (int k = 0; k < NV; k++) begin
         wr_reg(A_MODE, VEC[k][47:40]);
         wr_reg(A_DUAL, VEC[k][39:32]);
         wr_reg(A_POL,  VEC[k][31:24]);
         pin_in = VEC[k][23:16];
         wait_cyc(5);
         wr_reg(A_ACK, 8'hFF);
         pin_in = VEC[k][15:8];
         wait_cyc(5);
         rd_reg(A_PEND, v);
         check($sformatf("R2/R3/R4 vector %0d", k), v, VEC[k][7:0]);
      end

      // R5 latency, falling edge on pin 0
      do_reset();
      pin_in = 8'h03;
      wait_cyc(5);
      wr_reg(A_ACK, 8'hFF);
      reg_addr = A_PEND;
      pin_in = 8'h00;
      @(posedge clk); @(posedge clk); @(negedge clk);
      #1 check("R5 not yet after two edges", reg_rdata, 8'h00);
      @(posedge clk); @(negedge clk);
      #1 check("R5 set on third edge", reg_rdata, 8'h03);

      // R8 partial acknowledge and zero readback
      wr_reg(A_ACK, 8'h02);
      rd_reg(A_PEND, v); check("R8 partial ack", v, 8'h01);
      rd_reg(A_ACK, v);  check("R8 ack reads zero", v, 8'h00);

      // R7 pending is read-only
      wr_reg(A_PEND, 8'h00);
      rd_reg(A_PEND, v); check("R7 write zero ignored", v, 8'h01);
      wr_reg(A_PEND, 8'hFC);
      rd_reg(A_PEND, v); check("R7 write ones ignored", v, 8'h01);

      // R9 enable, masked view and irq
      wr_reg(A_EN, 8'h02);
      rd_reg(A_ACT, v); check("R9 masked off", v, 8'h00);
      check("R9 irq low", {7'd0, irq}, 8'h00);
      wr_reg(A_EN, 8'h01);
      rd_reg(A_ACT, v); check("R9 masked on", v, 8'h01);
      check("R9 irq high", {7'd0, irq}, 8'h01);
      wr_reg(A_ACK, 8'h01);
      check("R9 irq drops after ack", {7'd0, irq}, 8'h00);

      // R8 event and acknowledge in the same cycle
      pin_in = 8'h01;
      wait_cyc(5);
      wr_reg(A_ACK, 8'hFF);
      pin_in = 8'h00;
      @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
      reg_wr = 1'b1; reg_addr = A_ACK; reg_wdata = 8'h01;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0;
      rd_reg(A_PEND, v); check("R8 event wins over ack", v, 8'h01);

      // R10 event coinciding with a configuration write is dropped
      wr_reg(A_POL, 8'h01);
      wait_cyc(3);
      wr_reg(A_ACK, 8'hFF);
      pin_in = 8'h01;
      @(posedge clk); @(negedge clk); @(posedge clk); @(negedge clk);
      reg_wr = 1'b1; reg_addr = A_DUAL; reg_wdata = 8'h00;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0;
      wait_cyc(4);
      rd_reg(A_PEND, v); check("R10 event during cfg write dropped", v, 8'h00);
      wr_reg(A_MODE, 8'h00);
      wait_cyc(4);
      rd_reg(A_PEND, v); check("R10 reconfig makes no event", v, 8'h00);

      // R6 level hold through acknowledge
      do_reset();
      wr_reg(A_MODE, 8'h01);
      wr_reg(A_POL, 8'h01);
      pin_in = 8'h01;
      wait_cyc(5);
      rd_reg(A_PEND, v); check("R6 level sets", v, 8'h01);
      wr_reg(A_ACK, 8'h01);
      rd_reg(A_PEND, v); check("R6 held while active", v, 8'h01);
      pin_in = 8'h00;
      wait_cyc(4);
      wr_reg(A_ACK, 8'h01);
      rd_reg(A_PEND, v); check("R6 clears once inactive", v, 8'h00);

      // R11 unmapped address
      rd_reg(A_NONE, v); check("R11 address 7 reads zero", v, 8'h00);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule